// File: doc/BRIEF.md
# PHY Management Register File

This block models the management register set of a 10/100 Ethernet PHY as a MAC-side management engine sees it. It holds sixteen 16-bit registers: a control word, a status word, two identity words, the local ability advertisement, the link partner ability word and general-purpose storage. A host issues single-cycle commands carrying a PHY address, a register address, write data and a three-bit command; the block answers reads with registered read data, a one-cycle valid pulse and a link-fail flag.

A `link_up` input stands in for the line state. Each change of it rewrites the link bit of the status word and the partner ability word, so software sees a plausible link without any real negotiation. Only one PHY address answers; others read as all ones, as an unpopulated management bus would.

Top module: `mgmt_phy_regs`

## Requirements
- R1: A command whose register address is 16 or above changes no register; a read of such an address returns 0x0000.
- R2: After `rst_n` low, with `link_up` low: reg0 = 0x1000, reg1 = 0x7868, reg2 = 0x2000, reg3 = 0x5C90, reg4 = 0x01E1, reg5..reg15 = 0x0000, `rd_valid` = 0, `link_fail` = 0.
- R3: A write to reg0 with bit 15 set stores nothing of the written value and restores every register to its R2 value, with the R6 link rule then applied for the current `link_up`.
- R4: A write to reg0 (bit 15 clear) or to reg4..reg15 stores the written 16-bit value.
- R5: Writes to reg1, reg2 and reg3 are ignored.
- R6: When `link_up` changes to 1, reg1 bit 2 is set and reg5 gains bits 8, 7, 6, 5 and 0 (mask 0x01E1); when it changes to 0, reg1 bit 2 clears and reg5 is ANDed with 0x01FF.
- R7: Only PHY address 1 responds: a read to another PHY address returns 0xFFFF and a write to another PHY address is dropped.
- R8: A read command sets `link_fail` to the inverse of `link_up`; while the last command issued had the scan bit set, `link_fail` follows the inverse of `link_up` every cycle, and otherwise holds.
- R9: `cmd` bit 2 is write, bit 1 is read, bit 0 is scan; `rd_valid` pulses for one cycle in the cycle after a read command, with `rd_data` holding the register contents from before any write in the same command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Line state, 1 = link established |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd | input | 3 | Command bits: 2 write, 1 read, 0 scan |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write command |
| rd_data | output | 16 | Data returned by the last read |
| rd_valid | output | 1 | One-cycle pulse after a read |
| link_fail | output | 1 | Inverse link state, updated on read or scan |

## Verification
The hardest state to reach is the partner ability word holding a mix of software-written bits and link-derived bits, since the link rule only fires on a change of `link_up` and only the low nine bits survive a link drop. The bench writes a pattern with bits on both sides of that boundary while the link is up, then drops the link and reads back the masked value. A control-word reset issued while the link is up covers the reset path combined with the link rule, and a scan command followed by link toggles without reads covers the tracking of `link_fail`.

// File: rtl/mphy_pkg.sv
package mphy_pkg;
  localparam int unsigned DW     = 16;
  localparam int unsigned AW     = 5;
  localparam int unsigned NREG   = 16;

  localparam int unsigned CMD_WR   = 2;
  localparam int unsigned CMD_RD   = 1;
  localparam int unsigned CMD_SCAN = 0;

  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_STAT    = 1;
  localparam int unsigned IDX_ID_HI   = 2;
  localparam int unsigned IDX_ID_LO   = 3;
  localparam int unsigned IDX_ADV     = 4;
  localparam int unsigned IDX_PARTNER = 5;

  localparam logic [DW-1:0] CTRL_INIT    = 16'h1000;
  localparam logic [DW-1:0] STAT_INIT    = 16'h7868;
  localparam logic [DW-1:0] ID_HI_INIT   = 16'h2000;
  localparam logic [DW-1:0] ID_LO_INIT   = 16'h5C90;
  localparam logic [DW-1:0] ADV_INIT     = 16'h01E1;
  localparam logic [DW-1:0] PARTNER_UP   = 16'h01E1;
  localparam logic [DW-1:0] PARTNER_KEEP = 16'h01FF;
  localparam int unsigned   STAT_LINK    = 2;
  localparam int unsigned   CTRL_RESET   = 15;

  function automatic logic [DW-1:0] init_word(input int unsigned idx);
    case (idx)
      IDX_CTRL:  return CTRL_INIT;
      IDX_STAT:  return STAT_INIT;
      IDX_ID_HI: return ID_HI_INIT;
      IDX_ID_LO: return ID_LO_INIT;
      IDX_ADV:   return ADV_INIT;
      default:   return '0;
    endcase
  endfunction

  function automatic logic is_read_only(input int unsigned idx);
    return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
  endfunction
endpackage

// File: rtl/mphy_regbank.sv
module mphy_regbank
  import mphy_pkg::*;
#(
  parameter int unsigned N_REG  = NREG,
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  localparam int unsigned IDX_W = $clog2(N_REG);

  logic [DATA_W-1:0] regs_q [N_REG];
  logic [DATA_W-1:0] regs_d [N_REG];
  logic              link_q;
  logic              wr_in_range;
  logic              soft_rst;
  logic              link_chg;

  assign wr_in_range = (wr_idx < ADDR_W'(N_REG));
  assign soft_rst    = wr_en && wr_in_range && (wr_idx == ADDR_W'(IDX_CTRL))
                       && wr_val[CTRL_RESET];
  assign link_chg    = (link_up != link_q);

  always_comb begin
    for (int i = 0; i < int'(N_REG); i++) regs_d[i] = regs_q[i];
    if (soft_rst) begin
      for (int i = 0; i < int'(N_REG); i++) regs_d[i] = init_word(i);
    end else if (wr_en && wr_in_range && !is_read_only(int'(wr_idx))) begin
      regs_d[wr_idx[IDX_W-1:0]] = wr_val;
    end
    if (soft_rst || link_chg) begin
      if (link_up) begin
        regs_d[IDX_STAT][STAT_LINK] = 1'b1;
        regs_d[IDX_PARTNER]         = regs_d[IDX_PARTNER] | PARTNER_UP;
      end else begin
        regs_d[IDX_STAT][STAT_LINK] = 1'b0;
        regs_d[IDX_PARTNER]         = regs_d[IDX_PARTNER] & PARTNER_KEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_REG); i++) regs_q[i] <= init_word(i);
      link_q <= 1'b0;
    end else begin
      for (int i = 0; i < int'(N_REG); i++) regs_q[i] <= regs_d[i];
      link_q <= link_up;
    end
  end

  assign rd_word = (rd_idx < ADDR_W'(N_REG)) ? regs_q[rd_idx[IDX_W-1:0]] : '0;

  // R5: identity word survives a write aimed at it
  a_r5_id_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == ADDR_W'(IDX_ID_HI)) |=> $stable(regs_q[IDX_ID_HI]));

  // R3: control reset bit reloads the control word
  a_r3_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs_q[IDX_CTRL] == CTRL_INIT));

  // R6: link bit follows a link change
  a_r6_link_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (link_chg && !soft_rst) |=> (regs_q[IDX_STAT][STAT_LINK] == $past(link_up)));

  // R1: out-of-range write leaves the control word alone
  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_in_range) |=> $stable(regs_q[IDX_CTRL]));
endmodule

// File: rtl/mphy_host_port.sv
module mphy_host_port
  import mphy_pkg::*;
#(
  parameter int unsigned DATA_W   = DW,
  parameter int unsigned ADDR_W   = AW,
  parameter int unsigned PHY_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              link_up,
  input  logic [DATA_W-1:0] reg_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_idx,
  output logic [DATA_W-1:0] wr_val,
  output logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              link_fail
);
  logic              hit;
  logic              rd_cmd;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic              rd_valid_q, rd_valid_d;
  logic              scan_q, scan_d;
  logic              fail_q, fail_d;

  assign hit    = (phy_addr == ADDR_W'(PHY_ADDR));
  assign rd_cmd = cmd_valid && cmd[CMD_RD];
  assign wr_en  = cmd_valid && cmd[CMD_WR] && hit;
  assign wr_idx = reg_addr;
  assign wr_val = wr_data;
  assign rd_idx = reg_addr;

  always_comb begin
    rd_data_d  = rd_data_q;
    rd_valid_d = rd_cmd;
    scan_d     = cmd_valid ? cmd[CMD_SCAN] : scan_q;
    fail_d     = fail_q;
    if (rd_cmd) rd_data_d = hit ? reg_word : '1;
    if (rd_cmd || scan_q) fail_d = !link_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      scan_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
      scan_q     <= scan_d;
      fail_q     <= fail_d;
    end
  end

  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign link_fail = fail_q;

  // R7: foreign PHY read returns all ones
  a_r7_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !hit) |=> (rd_data == '1));

  // R8: read samples inverse link state
  a_r8_read_fail: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> (link_fail == !$past(link_up)));

  // R9: valid pulse only after a read
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_cmd));

  // R8: without read or scan the flag holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_cmd && !scan_q) |=> $stable(link_fail));
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mphy_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] phy_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          link_fail
);
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_val;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] reg_word;

  mphy_host_port #(.DATA_W(DW), .ADDR_W(AW), .PHY_ADDR(1)) u_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .link_up(link_up), .reg_word(reg_word), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_val(wr_val), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail)
  );

  mphy_regbank #(.N_REG(NREG), .DATA_W(DW), .ADDR_W(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_val(wr_val), .link_up(link_up), .rd_idx(rd_idx),
    .rd_word(reg_word)
  );
endmodule

// File: tb/mgmt_phy_regs_bench.sv
module mgmt_phy_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = '0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        link_fail;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mgmt_phy_regs u_mgmt_phy_regs (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .cmd_valid(cmd_valid),
    .cmd(cmd), .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail)
  );

  // fields: op(2: 0 write, 1 read), phy(5), reg(5), data(16), expect(16), req(4)
  localparam int NV = 17;
  localparam logic [47:0] VEC [NV] = '{
    {2'd1, 5'd1, 5'd0,  16'h0000, 16'h1000, 4'd2},  // R2 control
    {2'd1, 5'd1, 5'd1,  16'h0000, 16'h7868, 4'd2},  // R2 status
    {2'd1, 5'd1, 5'd2,  16'h0000, 16'h2000, 4'd2},  // R2 id hi
    {2'd1, 5'd1, 5'd3,  16'h0000, 16'h5C90, 4'd2},  // R2 id lo
    {2'd1, 5'd1, 5'd4,  16'h0000, 16'h01E1, 4'd2},  // R2 advert
    {2'd0, 5'd1, 5'd1,  16'hFFFF, 16'h0000, 4'd5},  // R5
    {2'd1, 5'd1, 5'd1,  16'h0000, 16'h7868, 4'd5},
    {2'd0, 5'd1, 5'd2,  16'h1234, 16'h0000, 4'd5},
    {2'd1, 5'd1, 5'd2,  16'h0000, 16'h2000, 4'd5},
    {2'd0, 5'd1, 5'd9,  16'hABCD, 16'h0000, 4'd4},  // R4
    {2'd1, 5'd1, 5'd9,  16'h0000, 16'hABCD, 4'd4},
    {2'd0, 5'd2, 5'd9,  16'h0000, 16'h0000, 4'd7},  // R7 dropped write
    {2'd1, 5'd1, 5'd9,  16'h0000, 16'hABCD, 4'd7},
    {2'd1, 5'd2, 5'd9,  16'h0000, 16'hFFFF, 4'd7},
    {2'd0, 5'd1, 5'd16, 16'h8000, 16'h0000, 4'd1},  // R1 no alias to reg0
    {2'd1, 5'd1, 5'd9,  16'h0000, 16'hABCD, 4'd1},
    {2'd1, 5'd1, 5'd16, 16'h0000, 16'h0000, 4'd1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; phy_addr = p; reg_addr = r; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = '0;
  endtask

  task automatic rd(input logic [4:0] r, input logic [15:0] exp, input string req);
    issue(3'b010, 5'd1, r, 16'h0);
    chk(req, rd_data, exp);
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 rd_valid", {15'd0, rd_valid}, 16'h0);
    chk("R2 link_fail", {15'd0, link_fail}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      if (v[47:46] == 2'd0) issue(3'b100, v[45:41], v[40:36], v[35:20]);
      else begin
        issue(3'b010, v[45:41], v[40:36], 16'h0);
        chk($sformatf("R%0d vector %0d", v[3:0], i), rd_data, v[19:4]);
      end
    end

    // R9: valid pulse lasts one cycle
    issue(3'b010, 5'd1, 5'd0, 16'h0);
    chk("R9 valid high", {15'd0, rd_valid}, 16'h1);
    @(negedge clk);
    chk("R9 valid low", {15'd0, rd_valid}, 16'h0);

    // R9: read and write together return the old value
    issue(3'b110, 5'd1, 5'd10, 16'h5A5A);
    chk("R9 read before write", rd_data, 16'h0000);
    rd(5'd10, 16'h5A5A, "R9 write landed");

    // R4 / R3: control store, then control reset
    issue(3'b100, 5'd1, 5'd0, 16'h0100);
    rd(5'd0, 16'h0100, "R4 control store");
    issue(3'b100, 5'd1, 5'd0, 16'h8000);
    rd(5'd0, 16'h1000, "R3 control reload");
    rd(5'd9, 16'h0000, "R3 general cleared");

    // R8: read while link down
    rd(5'd0, 16'h1000, "R8 dummy");
    chk("R8 fail when down", {15'd0, link_fail}, 16'h1);

    // R6: link up
    set_link(1'b1);
    rd(5'd1, 16'h786C, "R6 link bit set");
    chk("R8 fail when up", {15'd0, link_fail}, 16'h0);
    rd(5'd5, 16'h01E1, "R6 partner up");
    issue(3'b100, 5'd1, 5'd5, 16'hFF00);
    set_link(1'b0);
    rd(5'd1, 16'h7868, "R6 link bit clear");
    rd(5'd5, 16'h0100, "R6 partner masked");

    // R8: without a read or scan the flag holds
    set_link(1'b1);
    chk("R8 hold", {15'd0, link_fail}, 16'h1);
    set_link(1'b0);
    // R8: scan tracking
    issue(3'b001, 5'd1, 5'd0, 16'h0);
    set_link(1'b1);
    chk("R8 scan up", {15'd0, link_fail}, 16'h0);
    set_link(1'b0);
    chk("R8 scan down", {15'd0, link_fail}, 16'h1);
    issue(3'b000, 5'd1, 5'd0, 16'h0);
    set_link(1'b1);
    chk("R8 scan released", {15'd0, link_fail}, 16'h1);

    // R3: control reset with link up applies link rule
    issue(3'b100, 5'd1, 5'd5, 16'h0000);
    issue(3'b100, 5'd1, 5'd0, 16'h8000);
    rd(5'd1, 16'h786C, "R3 reset keeps link");
    rd(5'd5, 16'h01E1, "R3 reset partner");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule